// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory Entry

This block keeps one directory entry for a memory block at its home node. Sharers are not tracked with one presence bit per node. The entry instead holds a small, fixed set of pointer slots. Each slot has its own valid bit and stores one node number that is log2 of the node count wide. A dirty flag marks an exclusive owner. An overflow flag records that more sharers existed than the slots could hold.

The home protocol engine presents one request per cycle: a node number and an operation, which is read, write or eviction. One cycle later the block updates the entry and gives a response. The response is either a mask of pointer slots whose nodes must be invalidated, or a flag that demands invalidation of every node. It also reports any recall needed from a dirty owner, and pulses when the pointer set first overflows. Messaging and transport lie outside the block.

Top module: `dir_lptr_entry`

## Requirements
- R1: After synchronous reset, every slot is invalid, the dirty and overflow flags are 0, `owner_id` is 0 and `rsp_valid` is 0.
- R2: A read (`req_op`=0) from a node not held in any valid slot stores that node in the lowest-index invalid slot.
- R3: A read from a node already held in a valid slot leaves the entry unchanged and takes no second slot. No two valid slots ever hold the same node.
- R4: A read from a new node when all slots are valid leaves the slots unchanged. If the overflow flag was 0, it becomes 1 and `rsp_overflow` pulses with the response. If the flag was already 1, nothing changes and there is no pulse.
- R5: A write (`req_op`=1) leaves exactly one valid slot, slot 0, holding the writer. It sets the dirty flag and clears the overflow flag. While dirty, `owner_id` shows slot 0's node.
- R6: The response to a write carries `rsp_inval_mask` with every slot that was valid and held a node other than the writer. `rsp_inval_ptr` carries the slot contents from before the write. `rsp_inval_all` equals the overflow flag held before the write.
- R7: A read or write from a node other than the owner while dirty raises `rsp_recall`, with `rsp_owner` set to the owner's node. A read then clears the dirty flag, keeps the owner in slot 0 and adds the reader as in R2.
- R8: An eviction (`req_op`=2) invalidates the slot that holds the requester. If the requester was the dirty owner, the dirty flag clears. The overflow flag is kept. A freed slot is reused by the next new reader as in R2.
- R9: A response appears, with `rsp_valid` high, exactly one cycle after each request. Without a request, and for `req_op`=3, the entry does not change. Without a request, `rsp_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 eviction, 3 no operation |
| req_node | input | PTR_W | Requesting node number |
| ent_valid | output | SLOTS | Valid bit per pointer slot |
| ent_ptr | output | SLOTS x PTR_W | Node number per pointer slot |
| ent_dirty | output | 1 | Exclusive owner recorded in slot 0 |
| ent_bcast | output | 1 | Sharer set has overflowed |
| owner_id | output | PTR_W | Owner node while dirty, else 0 |
| rsp_valid | output | 1 | Response strobe |
| rsp_inval_mask | output | SLOTS | Slots whose nodes must be invalidated |
| rsp_inval_ptr | output | SLOTS x PTR_W | Slot contents before the request |
| rsp_inval_all | output | 1 | Invalidate every node |
| rsp_recall | output | 1 | Owner must return its dirty copy |
| rsp_owner | output | PTR_W | Owner node for the recall |
| rsp_overflow | output | 1 | Overflow flag was just set |

## Verification
Duplicate matching and overflow detection both act on one read when every slot is full and the reader is already listed. The duplicate match must win. The bench fills all five slots and then reads again from one of the listed nodes. The case passes only if the overflow flag stays 0, no overflow pulse appears and the slot contents are unchanged. A following read from an unlisted node must then produce the pulse.

// File: rtl/dir_lptr_pkg.sv
package dir_lptr_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_EVICT = 2'd2,
        OP_NONE  = 2'd3
    } dir_op_e;

    function automatic int ptr_width(input int nodes);
        return (nodes > 1) ? $clog2(nodes) : 1;
    endfunction

endpackage

// File: rtl/dir_lptr_match.sv
module dir_lptr_match #(
    parameter int SLOTS = 5,
    parameter int PTR_W = 10
) (
    input  logic [SLOTS-1:0]            valid,
    input  logic [SLOTS-1:0][PTR_W-1:0] ptr,
    input  logic [PTR_W-1:0]            node,
    output logic [SLOTS-1:0]            hit_vec,
    output logic                        hit,
    output logic [SLOTS-1:0]            free_oh,
    output logic                        any_free
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (ptr[g] == node);
    end

    assign hit      = |hit_vec;
    assign any_free = ~&valid;

    always_comb begin
        logic found;
        found   = 1'b0;
        free_oh = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (!valid[i] && !found) begin
                free_oh[i] = 1'b1;
                found      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dir_lptr_next.sv
module dir_lptr_next
    import dir_lptr_pkg::*;
#(
    parameter int SLOTS = 5,
    parameter int PTR_W = 10
) (
    input  logic                        req_valid,
    input  dir_op_e                     op,
    input  logic [PTR_W-1:0]            node,
    input  logic [SLOTS-1:0]            cur_valid,
    input  logic [SLOTS-1:0][PTR_W-1:0] cur_ptr,
    input  logic                        cur_dirty,
    input  logic                        cur_bcast,
    input  logic [SLOTS-1:0]            hit_vec,
    input  logic                        hit,
    input  logic [SLOTS-1:0]            free_oh,
    input  logic                        any_free,
    output logic [SLOTS-1:0]            nxt_valid,
    output logic [SLOTS-1:0][PTR_W-1:0] nxt_ptr,
    output logic                        nxt_dirty,
    output logic                        nxt_bcast,
    output logic [SLOTS-1:0]            inval_mask,
    output logic                        inval_all,
    output logic                        recall,
    output logic                        overflow
);
    always_comb begin
        nxt_valid  = cur_valid;
        nxt_ptr    = cur_ptr;
        nxt_dirty  = cur_dirty;
        nxt_bcast  = cur_bcast;
        inval_mask = '0;
        inval_all  = 1'b0;
        recall     = 1'b0;
        overflow   = 1'b0;
        if (req_valid) begin
            unique case (op)
                OP_READ: begin
                    if (!hit) begin
                        if (cur_dirty) begin
                            recall    = 1'b1;
                            nxt_dirty = 1'b0;
                        end
                        if (any_free) begin
                            for (int i = 0; i < SLOTS; i++) begin
                                if (free_oh[i]) begin
                                    nxt_valid[i] = 1'b1;
                                    nxt_ptr[i]   = node;
                                end
                            end
                        end else if (!cur_bcast) begin
                            nxt_bcast = 1'b1;
                            overflow  = 1'b1;
                        end
                    end
                end
                OP_WRITE: begin
                    inval_mask = cur_valid & ~hit_vec;
                    inval_all  = cur_bcast;
                    recall     = cur_dirty && !hit;
                    nxt_valid  = '0;
                    nxt_valid[0] = 1'b1;
                    nxt_ptr    = '0;
                    nxt_ptr[0] = node;
                    nxt_dirty  = 1'b1;
                    nxt_bcast  = 1'b0;
                end
                OP_EVICT: begin
                    nxt_valid = cur_valid & ~hit_vec;
                    if (cur_dirty && hit) begin
                        nxt_dirty = 1'b0;
                    end
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/dir_lptr_entry.sv
module dir_lptr_entry
    import dir_lptr_pkg::*;
#(
    parameter  int NODES = 1024,
    parameter  int SLOTS = 5,
    localparam int PTR_W = ptr_width(NODES)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic [1:0]                  req_op,
    input  logic [PTR_W-1:0]            req_node,
    output logic [SLOTS-1:0]            ent_valid,
    output logic [SLOTS-1:0][PTR_W-1:0] ent_ptr,
    output logic                        ent_dirty,
    output logic                        ent_bcast,
    output logic [PTR_W-1:0]            owner_id,
    output logic                        rsp_valid,
    output logic [SLOTS-1:0]            rsp_inval_mask,
    output logic [SLOTS-1:0][PTR_W-1:0] rsp_inval_ptr,
    output logic                        rsp_inval_all,
    output logic                        rsp_recall,
    output logic [PTR_W-1:0]            rsp_owner,
    output logic                        rsp_overflow
);
    logic [SLOTS-1:0]            hit_vec, free_oh;
    logic                        hit, any_free;
    logic [SLOTS-1:0]            nxt_valid, inval_mask;
    logic [SLOTS-1:0][PTR_W-1:0] nxt_ptr;
    logic                        nxt_dirty, nxt_bcast, inval_all, recall, overflow;
    dir_op_e                     op;

    assign op = dir_op_e'(req_op);

    dir_lptr_match #(.SLOTS(SLOTS), .PTR_W(PTR_W)) u_match (
        .valid    (ent_valid),
        .ptr      (ent_ptr),
        .node     (req_node),
        .hit_vec  (hit_vec),
        .hit      (hit),
        .free_oh  (free_oh),
        .any_free (any_free)
    );

    dir_lptr_next #(.SLOTS(SLOTS), .PTR_W(PTR_W)) u_next (
        .req_valid  (req_valid),
        .op         (op),
        .node       (req_node),
        .cur_valid  (ent_valid),
        .cur_ptr    (ent_ptr),
        .cur_dirty  (ent_dirty),
        .cur_bcast  (ent_bcast),
        .hit_vec    (hit_vec),
        .hit        (hit),
        .free_oh    (free_oh),
        .any_free   (any_free),
        .nxt_valid  (nxt_valid),
        .nxt_ptr    (nxt_ptr),
        .nxt_dirty  (nxt_dirty),
        .nxt_bcast  (nxt_bcast),
        .inval_mask (inval_mask),
        .inval_all  (inval_all),
        .recall     (recall),
        .overflow   (overflow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_valid      <= '0;
            ent_ptr        <= '0;
            ent_dirty      <= 1'b0;
            ent_bcast      <= 1'b0;
            rsp_valid      <= 1'b0;
            rsp_inval_mask <= '0;
            rsp_inval_ptr  <= '0;
            rsp_inval_all  <= 1'b0;
            rsp_recall     <= 1'b0;
            rsp_owner      <= '0;
            rsp_overflow   <= 1'b0;
        end else begin
            ent_valid      <= nxt_valid;
            ent_ptr        <= nxt_ptr;
            ent_dirty      <= nxt_dirty;
            ent_bcast      <= nxt_bcast;
            rsp_valid      <= req_valid;
            rsp_inval_mask <= inval_mask;
            rsp_inval_ptr  <= ent_ptr;
            rsp_inval_all  <= inval_all;
            rsp_recall     <= recall;
            rsp_owner      <= recall ? ent_ptr[0] : '0;
            rsp_overflow   <= overflow;
        end
    end

    assign owner_id = ent_dirty ? ent_ptr[0] : '0;
endmodule

// File: rtl/dir_lptr_chk.sv
module dir_lptr_chk #(
    parameter int SLOTS = 5,
    parameter int PTR_W = 10
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        req_valid,
    input logic [1:0]                  req_op,
    input logic [PTR_W-1:0]            req_node,
    input logic [SLOTS-1:0]            ent_valid,
    input logic [SLOTS-1:0][PTR_W-1:0] ent_ptr,
    input logic                        ent_dirty,
    input logic                        ent_bcast,
    input logic                        rsp_valid,
    input logic                        rsp_overflow
);
    // R5: dirty implies a single valid pointer in slot 0 and no overflow
    p_dirty_single_r5: assert property (@(posedge clk) disable iff (rst)
        ent_dirty |-> ($countones(ent_valid) == 1) && ent_valid[0] && !ent_bcast);

    p_write_owner_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd1) |=> ent_dirty && (ent_ptr[0] == $past(req_node)));

    p_overflow_rise_r4: assert property (@(posedge clk) disable iff (rst)
        rsp_overflow |-> ent_bcast && !$past(ent_bcast) && (&ent_valid));

    p_idle_stable_r9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(ent_valid) && $stable(ent_ptr) && $stable(ent_dirty)
                       && $stable(ent_bcast) && !rsp_valid);

    p_rsp_follows_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid));

    for (genvar i = 0; i < SLOTS; i++) begin : g_a
        for (genvar j = i + 1; j < SLOTS; j++) begin : g_b
            p_no_dup_r3: assert property (@(posedge clk) disable iff (rst)
                (ent_valid[i] && ent_valid[j]) |-> (ent_ptr[i] != ent_ptr[j]));
        end
    end
endmodule

bind dir_lptr_entry dir_lptr_chk #(.SLOTS(SLOTS), .PTR_W(PTR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_op       (req_op),
    .req_node     (req_node),
    .ent_valid    (ent_valid),
    .ent_ptr      (ent_ptr),
    .ent_dirty    (ent_dirty),
    .ent_bcast    (ent_bcast),
    .rsp_valid    (rsp_valid),
    .rsp_overflow (rsp_overflow)
);

// File: tb/dir_lptr_entry_bench.sv
module dir_lptr_entry_bench;
    localparam int CLK_P = 10;
    localparam int NODES = 1024;
    localparam int SLOTS = 5;
    localparam int PTR_W = 10;

    logic                        clk = 1'b0;
    logic                        rst = 1'b1;
    logic                        req_valid = 1'b0;
    logic [1:0]                  req_op = 2'd0;
    logic [PTR_W-1:0]            req_node = '0;
    logic [SLOTS-1:0]            ent_valid;
    logic [SLOTS-1:0][PTR_W-1:0] ent_ptr;
    logic                        ent_dirty, ent_bcast;
    logic [PTR_W-1:0]            owner_id;
    logic                        rsp_valid;
    logic [SLOTS-1:0]            rsp_inval_mask;
    logic [SLOTS-1:0][PTR_W-1:0] rsp_inval_ptr;
    logic                        rsp_inval_all, rsp_recall, rsp_overflow;
    logic [PTR_W-1:0]            rsp_owner;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    dir_lptr_entry #(.NODES(NODES), .SLOTS(SLOTS)) u_dir_lptr_entry (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_node(req_node), .ent_valid(ent_valid), .ent_ptr(ent_ptr),
        .ent_dirty(ent_dirty), .ent_bcast(ent_bcast), .owner_id(owner_id),
        .rsp_valid(rsp_valid), .rsp_inval_mask(rsp_inval_mask),
        .rsp_inval_ptr(rsp_inval_ptr), .rsp_inval_all(rsp_inval_all),
        .rsp_recall(rsp_recall), .rsp_owner(rsp_owner), .rsp_overflow(rsp_overflow)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input int node);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_node  = node[PTR_W-1:0];
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 valid", 64'(ent_valid), 0);
        chk("R1 dirty", 64'(ent_dirty), 0);
        chk("R1 bcast", 64'(ent_bcast), 0);
        chk("R1 owner", 64'(owner_id), 0);
        chk("R1 rsp_valid", 64'(rsp_valid), 0);
        rst = 1'b0;
    endtask

    task automatic t_fill;
        issue(2'd0, 7);
        chk("R9 rsp_valid", 64'(rsp_valid), 1);
        issue(2'd0, 3);
        issue(2'd0, 900);
        chk("R2 valid", 64'(ent_valid), 64'b00111);
        chk("R2 slot0", 64'(ent_ptr[0]), 7);
        chk("R2 slot1", 64'(ent_ptr[1]), 3);
        chk("R2 slot2", 64'(ent_ptr[2]), 900);
    endtask

    task automatic t_duplicate_full;
        issue(2'd0, 3);
        chk("R3 dup valid", 64'(ent_valid), 64'b00111);
        issue(2'd0, 12);
        issue(2'd0, 44);
        chk("R2 full valid", 64'(ent_valid), 64'b11111);
        chk("R2 slot4", 64'(ent_ptr[4]), 44);
        issue(2'd0, 900);
        chk("R3 full dup no overflow", 64'(rsp_overflow), 0);
        chk("R3 full dup bcast", 64'(ent_bcast), 0);
        chk("R3 full dup slot2", 64'(ent_ptr[2]), 900);
    endtask

    task automatic t_overflow;
        issue(2'd0, 500);
        chk("R4 pulse", 64'(rsp_overflow), 1);
        chk("R4 bcast", 64'(ent_bcast), 1);
        chk("R4 slots kept", 64'(ent_valid), 64'b11111);
        chk("R4 slot4 kept", 64'(ent_ptr[4]), 44);
        issue(2'd0, 501);
        chk("R4 no second pulse", 64'(rsp_overflow), 0);
        chk("R4 bcast held", 64'(ent_bcast), 1);
    endtask

    task automatic t_evict_reuse;
        issue(2'd2, 3);
        chk("R8 evict valid", 64'(ent_valid), 64'b11101);
        chk("R8 bcast kept", 64'(ent_bcast), 1);
        issue(2'd0, 600);
        chk("R8 reuse valid", 64'(ent_valid), 64'b11111);
        chk("R8 reuse slot1", 64'(ent_ptr[1]), 600);
    endtask

    task automatic t_write_bcast;
        issue(2'd1, 12);
        chk("R6 inval_all", 64'(rsp_inval_all), 1);
        chk("R6 mask", 64'(rsp_inval_mask), 64'b10111);
        chk("R6 ptr slot1", 64'(rsp_inval_ptr[1]), 600);
        chk("R7 no recall", 64'(rsp_recall), 0);
        chk("R5 valid", 64'(ent_valid), 64'b00001);
        chk("R5 slot0", 64'(ent_ptr[0]), 12);
        chk("R5 dirty", 64'(ent_dirty), 1);
        chk("R5 bcast clr", 64'(ent_bcast), 0);
        chk("R5 owner", 64'(owner_id), 12);
    endtask

    task automatic t_read_dirty;
        issue(2'd0, 77);
        chk("R7 recall", 64'(rsp_recall), 1);
        chk("R7 owner", 64'(rsp_owner), 12);
        chk("R7 dirty clr", 64'(ent_dirty), 0);
        chk("R7 valid", 64'(ent_valid), 64'b00011);
        chk("R7 slot0", 64'(ent_ptr[0]), 12);
        chk("R7 slot1", 64'(ent_ptr[1]), 77);
        chk("R7 owner_id", 64'(owner_id), 0);
    endtask

    task automatic t_write_list;
        issue(2'd1, 200);
        chk("R6 list mask", 64'(rsp_inval_mask), 64'b00011);
        chk("R6 list all", 64'(rsp_inval_all), 0);
        chk("R7 shared no recall", 64'(rsp_recall), 0);
        issue(2'd1, 200);
        chk("R6 self mask", 64'(rsp_inval_mask), 0);
        chk("R7 self no recall", 64'(rsp_recall), 0);
        issue(2'd1, 300);
        chk("R7 write recall", 64'(rsp_recall), 1);
        chk("R7 write owner", 64'(rsp_owner), 200);
        chk("R6 owner mask", 64'(rsp_inval_mask), 64'b00001);
        chk("R5 new owner", 64'(owner_id), 300);
    endtask

    task automatic t_evict_owner;
        issue(2'd2, 300);
        chk("R8 owner gone valid", 64'(ent_valid), 0);
        chk("R8 owner gone dirty", 64'(ent_dirty), 0);
    endtask

    task automatic t_idle;
        issue(2'd0, 5);
        issue(2'd3, 9);
        chk("R9 op3 valid", 64'(ent_valid), 64'b00001);
        chk("R9 op3 slot0", 64'(ent_ptr[0]), 5);
        repeat (4) @(negedge clk);
        chk("R9 idle rsp", 64'(rsp_valid), 0);
        chk("R9 idle valid", 64'(ent_valid), 64'b00001);
        chk("R9 idle slot0", 64'(ent_ptr[0]), 5);
    endtask

    initial begin
        t_reset();
        t_fill();
        t_duplicate_full();
        t_overflow();
        t_evict_reuse();
        t_write_bcast();
        t_read_dirty();
        t_write_list();
        t_evict_owner();
        t_idle();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule